// File: doc/BRIEF.md
# GPIO Pin Event Detector with Grouped Interrupts

This block watches 54 general-purpose input pins that have already been synchronized to the system clock. It records events in a sticky status bit per pin. Software selects the conditions that count as an event for each pin through four separate enable masks:

- rising edge
- falling edge
- high level
- low level

Any enabled condition sets the pin's status bit. Software clears a status bit by writing a one to it.

The status bits are collected onto three interrupt request lines. Each line covers a fixed range of pins, and the ranges do not line up with the 32-bit register words. Two further enable masks, for asynchronous rising and falling detection, are stored and can be read back, but they do not take part in detection.

Registers are reached over a simple single-cycle bus with address, write strobe, write data and combinational read data. Pins are split into 32-bit words: the lower word holds pins 0 to 31 in bits 0 to 31. The upper word holds pins 32 to 53 in bits 0 to 21, and its bits 22 to 31 always read zero. The address map is as follows:

| Register set | Lower word | Upper word |
|---|---|---|
| Status | 0x40 | 0x44 |
| Rising-edge enable | 0x4C | 0x50 |
| Falling-edge enable | 0x58 | 0x5C |
| High-level enable | 0x64 | 0x68 |
| Low-level enable | 0x70 | 0x74 |
| Asynchronous rising enable | 0x7C | 0x80 |
| Asynchronous falling enable | 0x88 | 0x8C |

Top module: `pin_event_unit`

## Requirements
- R1: After reset, every enable word and both status words read 0, and all three interrupt lines are low.
- R2: The four detect enable words are plain read/write registers: rising at 0x4C/0x50, falling at 0x58/0x5C, high at 0x64/0x68, low at 0x70/0x74. Bits 22 to 31 of an upper word always read 0.
- R3: The asynchronous enable words at 0x7C/0x80 and 0x88/0x8C read back what was written, and they never set a status bit.
- R4: A pin with its rising enable set gets its status bit set at the first clock edge that samples the pin high after a sample of it low. A pin that stays high does not set the bit again.
- R5: A pin with its falling enable set gets its status bit set at the first clock edge that samples the pin low after a sample of it high.
- R6: A pin with both edge enables set captures either edge.
- R7: A pin with its high-level (low-level) enable set gets its status bit set on every clock edge at which it is sampled high (low). A clear written while the level persists leaves the bit set.
- R8: Writing to 0x40/0x44 clears the status bits written as 1, and leaves the bits written as 0 unchanged.
- R9: A status bit stays set after the pin's enables are turned off, until it is cleared by a write.
- R10: When an event and a clear hit the same status bit on the same clock edge, the bit ends up set.
- R11: irq_out[0] is the OR of the status bits of pins 0 to 27, irq_out[1] that of pins 28 to 45, and irq_out[2] that of pins 46 to 53.
- R12: While all enables are 0, pin activity leaves every status bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| bus_addr | input | 8 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| pin_in | input | 54 | Pin levels, already synchronized to clk |
| irq_out | output | 3 | Interrupt lines for the three pin ranges |

## Verification
The assertions assume several things about the inputs:

- pin_in is free of metastability and changes only between clock edges.
- The bus address and data are stable while the write strobe is high.
- No input is unknown once the synchronized reset is released.

The bench keeps within these assumptions by changing pins and bus signals only on the falling clock edge and by holding every input at a defined value from time zero. It also issues at most one write per cycle, with the strobe dropped on the next falling edge.

// File: rtl/pev_pkg.sv
package pev_pkg;
  localparam int BANK_W      = 32;
  localparam int NUM_KINDS   = 6;
  localparam int NUM_SETS    = NUM_KINDS + 1;
  localparam int KIND_RISE   = 0;
  localparam int KIND_FALL   = 1;
  localparam int KIND_HIGH   = 2;
  localparam int KIND_LOW    = 3;
  localparam int KIND_ARISE  = 4;
  localparam int KIND_AFALL  = 5;
  localparam int MAP_BASE    = 'h40;
  localparam int SET_STRIDE  = 'h0C;
  localparam int WORD_STRIDE = 4;

  // set 0 is the status word pair, sets 1..6 are the enable kinds
  function automatic int word_addr(input int set_idx, input int bank);
    return MAP_BASE + set_idx * SET_STRIDE + bank * WORD_STRIDE;
  endfunction

  function automatic int bank_count(input int pins);
    return (pins + BANK_W - 1) / BANK_W;
  endfunction
endpackage

// File: rtl/pev_rst_sync.sv
module pev_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pev_bus_if.sv
module pev_bus_if
  import pev_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8,
  parameter int NB       = 2
) (
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [NUM_PINS-1:0]    reg_sets [NUM_SETS],
  output logic [NUM_SETS*NB-1:0] wr_stb,
  output logic [BANK_W-1:0]      bus_rdata
);
  localparam int PAD_W = NB * BANK_W;

  logic [PAD_W-1:0]       pad_v [NUM_SETS];
  logic [NUM_SETS*NB-1:0] word_sel;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    assign pad_v[s] = PAD_W'(reg_sets[s]);
    for (genvar b = 0; b < NB; b++) begin : g_bank
      assign word_sel[s*NB+b] = (int'(bus_addr) == word_addr(s, b));
    end
  end

  assign wr_stb = {(NUM_SETS*NB){bus_we}} & word_sel;

  always_comb begin
    bus_rdata = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      for (int b = 0; b < NB; b++) begin
        if (word_sel[s*NB+b]) bus_rdata = pad_v[s][b*BANK_W +: BANK_W];
      end
    end
  end
endmodule

// File: rtl/pev_cfg_regs.sv
module pev_cfg_regs
  import pev_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int NB       = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_KINDS*NB-1:0] kind_stb,
  input  logic [BANK_W-1:0]       bus_wdata,
  output logic [NUM_PINS-1:0]     kind_q [NUM_KINDS]
);
  logic [NUM_PINS-1:0] kind_d [NUM_KINDS];
  logic                cfg_en;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assign kind_d[k][i] = kind_stb[k*NB + i/BANK_W] ? bus_wdata[i%BANK_W]
                                                      : kind_q[k][i];
    end
  end

  assign cfg_en = |kind_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_KINDS; k++) kind_q[k] <= '0;
    end else if (cfg_en) begin
      kind_q <= kind_d;
    end
  end
endmodule

// File: rtl/pev_event_core.sv
module pev_event_core
  import pev_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int NB       = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] en_rise,
  input  logic [NUM_PINS-1:0] en_fall,
  input  logic [NUM_PINS-1:0] en_high,
  input  logic [NUM_PINS-1:0] en_low,
  input  logic [NB-1:0]       stat_stb,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [NUM_PINS-1:0] status_q
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] clr;
  logic [NUM_PINS-1:0] status_d;
  logic                st_en;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_clr
    assign clr[i] = stat_stb[i/BANK_W] & bus_wdata[i%BANK_W];
  end

  always_comb begin
    hit = (en_rise & pin_in & ~prev_q)
        | (en_fall & ~pin_in & prev_q)
        | (en_high & pin_in)
        | (en_low & ~pin_in);
    // a new event outranks a clear of the same bit
    status_d = (status_q & ~clr) | hit;
    st_en    = (|hit) | (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_q <= '0;
    else if (st_en) status_q <= status_d;
  end
endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
  import pev_pkg::*;
#(
  parameter int NUM_PINS   = 54,
  parameter int ADDR_W     = 8,
  parameter int IRQ1_FIRST = 28,
  parameter int IRQ2_FIRST = 46
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [2:0]          irq_out
);
  localparam int NB        = bank_count(NUM_PINS);
  localparam int NUM_LINES = 3;

  logic                   rst_core_n;
  logic [NUM_SETS*NB-1:0] wr_stb;
  logic [NUM_PINS-1:0]    kind_q   [NUM_KINDS];
  logic [NUM_PINS-1:0]    reg_sets [NUM_SETS];
  logic [NUM_PINS-1:0]    status_q;
  logic [NUM_PINS-1:0]    en_rise, en_fall, en_high, en_low;

  pev_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  pev_bus_if #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .NB(NB)) u_bus (
    .bus_addr(bus_addr), .bus_we(bus_we), .reg_sets(reg_sets),
    .wr_stb(wr_stb), .bus_rdata(bus_rdata)
  );

  pev_cfg_regs #(.NUM_PINS(NUM_PINS), .NB(NB)) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .kind_stb(wr_stb[NUM_SETS*NB-1:NB]),
    .bus_wdata(bus_wdata), .kind_q(kind_q)
  );

  assign en_rise = kind_q[KIND_RISE];
  assign en_fall = kind_q[KIND_FALL];
  assign en_high = kind_q[KIND_HIGH];
  assign en_low  = kind_q[KIND_LOW];

  pev_event_core #(.NUM_PINS(NUM_PINS), .NB(NB)) u_evt (
    .clk(clk), .rst_n(rst_core_n), .pin_in(pin_in),
    .en_rise(en_rise), .en_fall(en_fall), .en_high(en_high), .en_low(en_low),
    .stat_stb(wr_stb[NB-1:0]), .bus_wdata(bus_wdata), .status_q(status_q)
  );

  assign reg_sets[0] = status_q;
  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_rd
    assign reg_sets[k+1] = kind_q[k];
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_irq
    localparam int LO = (g == 0) ? 0 : (g == 1) ? IRQ1_FIRST : IRQ2_FIRST;
    localparam int HI = (g == 0) ? IRQ1_FIRST - 1
                      : (g == 1) ? IRQ2_FIRST - 1 : NUM_PINS - 1;
    assign irq_out[g] = |status_q[HI:LO];
  end
endmodule

// File: rtl/pin_event_unit_chk.sv
module pin_event_unit_chk
  import pev_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] en_rise,
  input logic [NUM_PINS-1:0] en_high,
  input logic [NUM_PINS-1:0] en_low,
  input logic [NUM_PINS-1:0] status_q,
  input logic [2:0]          irq_out
);
  localparam int NB = bank_count(NUM_PINS);
  logic stat_touch;

  assign stat_touch = bus_we && (int'(bus_addr) >= MAP_BASE)
                      && (int'(bus_addr) < MAP_BASE + NB * WORD_STRIDE);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_touch |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_level_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_high & pin_in)) |=>
      ((status_q & $past(en_high & pin_in)) == $past(en_high & pin_in)));

  assert_level_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_low & ~pin_in)) |=>
      ((status_q & $past(en_low & ~pin_in)) == $past(en_low & ~pin_in)));

  assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_rise & pin_in & ~$past(pin_in))) |=>
      ((status_q & $past(en_rise & pin_in & ~$past(pin_in)))
        == $past(en_rise & pin_in & ~$past(pin_in))));

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> (irq_out == 3'b000));

  assert_irq_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != '0) |-> (irq_out != 3'b000));
endmodule

bind pin_event_unit pin_event_unit_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .pin_in(pin_in), .en_rise(en_rise), .en_high(en_high), .en_low(en_low),
  .status_q(status_q), .irq_out(irq_out)
);

// File: tb/pin_event_unit_bench.sv
module pin_event_unit_bench;
  localparam int NP = 54;
  localparam int NVEC = 8;
  localparam int VEC_PIN [NVEC] = '{0, 27, 28, 31, 32, 45, 46, 53};
  localparam logic [2:0] VEC_IRQ [NVEC] =
    '{3'b001, 3'b001, 3'b010, 3'b010, 3'b010, 3'b010, 3'b100, 3'b100};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pins = '0;
  logic [2:0]    irq;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_event_unit u_pin_event_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pins), .irq_out(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; we = 1'b0; #1;
    chk(req, rdata, exp);
  endtask

  task automatic setpin(input int idx, input logic v);
    @(negedge clk); pins[idx] = v;
  endtask

  task automatic clean();
    for (int k = 0; k < 6; k++) begin
      wr(8'(8'h4C + 12*k), 32'h0);
      wr(8'(8'h50 + 12*k), 32'h0);
    end
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {29'b0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 7; s++) begin
      rdchk("R1", 8'(8'h40 + 12*s), 32'h0);
      rdchk("R1", 8'(8'h44 + 12*s), 32'h0);
    end
    chk("R1 irq", {29'b0, irq}, 32'h0);

    // R12: activity with no enables
    @(negedge clk); pins = '1;
    @(negedge clk); pins = '0;
    @(negedge clk); pins = 54'h15_5555_5555_5555;
    @(negedge clk); pins = '0;
    @(negedge clk);
    rdchk("R12", 8'h40, 32'h0);
    rdchk("R12", 8'h44, 32'h0);
    chk("R12 irq", {29'b0, irq}, 32'h0);

    // R2: enable words read/write, unused upper bits read 0
    wr(8'h50, 32'hFFFF_FFFF);
    rdchk("R2 upper mask", 8'h50, 32'h003F_FFFF);
    wr(8'h64, 32'hA5A5_A5A5);
    rdchk("R2 high word", 8'h64, 32'hA5A5_A5A5);
    wr(8'h74, 32'h0012_3456);
    rdchk("R2 low word", 8'h74, 32'h0012_3456);
    clean();

    // R3: asynchronous enables stored only
    wr(8'h7C, 32'h0000_0002);
    wr(8'h8C, 32'h0030_0000);
    rdchk("R3", 8'h7C, 32'h0000_0002);
    rdchk("R3", 8'h8C, 32'h0030_0000);
    setpin(1, 1'b1); setpin(1, 1'b0); setpin(52, 1'b1); setpin(52, 1'b0);
    @(negedge clk);
    rdchk("R3 no status", 8'h40, 32'h0);
    rdchk("R3 no status", 8'h44, 32'h0);
    clean();

    // R11: interrupt grouping table
    for (int v = 0; v < NVEC; v++) begin
      wr(8'(8'h64 + 4*(VEC_PIN[v]/32)), 32'h1 << (VEC_PIN[v] % 32));
      setpin(VEC_PIN[v], 1'b1);
      @(negedge clk);
      chk($sformatf("R11 pin %0d", VEC_PIN[v]), {29'b0, irq}, {29'b0, VEC_IRQ[v]});
      setpin(VEC_PIN[v], 1'b0);
      clean();
      chk("R11 cleared", {29'b0, irq}, 32'h0);
    end

    // R4: rising edge on pin 5
    wr(8'h4C, 32'h20);
    rdchk("R4 before edge", 8'h40, 32'h0);
    setpin(5, 1'b1);
    @(negedge clk);
    rdchk("R4 edge", 8'h40, 32'h20);
    chk("R4 irq", {29'b0, irq}, 32'h1);
    wr(8'h40, 32'h20);
    @(negedge clk);
    rdchk("R4 held high no retrigger", 8'h40, 32'h0);
    setpin(5, 1'b0);
    @(negedge clk);
    rdchk("R4 fall ignored", 8'h40, 32'h0);
    clean();

    // R5: falling edge on pin 40 (upper word bit 8)
    setpin(40, 1'b1);
    wr(8'h5C, 32'h100);
    @(negedge clk);
    rdchk("R5 before edge", 8'h44, 32'h0);
    setpin(40, 1'b0);
    @(negedge clk);
    rdchk("R5 edge", 8'h44, 32'h100);
    chk("R5 irq", {29'b0, irq}, 32'h2);
    clean();

    // R6: both edges on pin 10
    wr(8'h4C, 32'h400);
    wr(8'h58, 32'h400);
    setpin(10, 1'b1);
    @(negedge clk);
    rdchk("R6 rise", 8'h40, 32'h400);
    wr(8'h40, 32'h400);
    rdchk("R6 cleared", 8'h40, 32'h0);
    setpin(10, 1'b0);
    @(negedge clk);
    rdchk("R6 fall", 8'h40, 32'h400);
    clean();

    // R7 / R9: high level on pin 50 (upper word bit 18)
    wr(8'h68, 32'h0004_0000);
    setpin(50, 1'b1);
    @(negedge clk);
    rdchk("R7 high", 8'h44, 32'h0004_0000);
    chk("R7 irq", {29'b0, irq}, 32'h4);
    wr(8'h44, 32'h0004_0000);
    @(negedge clk);
    rdchk("R7 clear during level", 8'h44, 32'h0004_0000);
    wr(8'h68, 32'h0);
    repeat (3) @(negedge clk);
    rdchk("R9 sticky", 8'h44, 32'h0004_0000);
    setpin(50, 1'b0);
    @(negedge clk);
    rdchk("R9 sticky after pin low", 8'h44, 32'h0004_0000);
    wr(8'h44, 32'h0004_0000);
    rdchk("R9 cleared", 8'h44, 32'h0);
    // low level on pin 3
    wr(8'h70, 32'h8);
    @(negedge clk);
    rdchk("R7 low", 8'h40, 32'h8);
    clean();

    // R8: zeros do not clear
    wr(8'h4C, 32'h80);
    setpin(7, 1'b1);
    @(negedge clk);
    wr(8'h40, 32'h0);
    rdchk("R8 zero write", 8'h40, 32'h80);
    wr(8'h40, 32'hFFFF_FF7F);
    rdchk("R8 other bits", 8'h40, 32'h80);
    wr(8'h40, 32'h80);
    rdchk("R8 clear", 8'h40, 32'h0);
    setpin(7, 1'b0);
    clean();

    // R10: event and clear on the same edge
    wr(8'h4C, 32'h0010_0000);
    setpin(20, 1'b1);
    @(negedge clk);
    rdchk("R10 setup", 8'h40, 32'h0010_0000);
    setpin(20, 1'b0);
    @(negedge clk);
    pins[20] = 1'b1; addr = 8'h40; wdata = 32'h0010_0000; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rdchk("R10 event wins", 8'h40, 32'h0010_0000);
    wr(8'h40, 32'h0010_0000);
    rdchk("R10 plain clear", 8'h40, 32'h0);
    setpin(20, 1'b0);
    clean();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule